// File: doc/BRIEF.md
# Idle-Driven Power Gating Sequencer with Break-Even Tracking

This block sits beside a unit that can be power-gated. It watches the unit's busy signal. Once the unit has been idle long enough, it decides to cut the unit's supply. It then waits for the switch network to confirm that the gate signal has propagated. While the unit is off, it measures how long the unit has stayed off. When work arrives again, it requests repower and keeps the unit marked not-ready until the supply is confirmed recharged.

Every gating episode is judged against a programmable break-even residency. Gating only saves energy if the unit stays off past that point. An episode that ends sooner is counted as wasted in a saturating counter, which lets the idle threshold be tuned from observation. Both the idle threshold and the break-even residency are plain inputs that a register elsewhere drives.

The controller has four states. RUN: the unit is powered and ready, and idle cycles are counted. GATE_WAIT: the off decision has been made and the propagation acknowledge is awaited. GATED: the supply is off and residency is counted. WAKE: repower is requested and the recharge acknowledge is awaited.

Its transitions are named as follows:
- *idle_expire*: RUN to GATE_WAIT.
- *gate_done*: GATE_WAIT to GATED.
- *early_wake*: GATE_WAIT to WAKE, when activity arrived during propagation.
- *demand*: GATED to WAKE.
- *wake_done*: WAKE to RUN.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `unit_ready_o`=1, `gate_req_o`=0, `repower_req_o`=0, `past_breakeven_o`=0 and `waste_count_o`=0.
- R2: In RUN, `gate_req_o` rises and `unit_ready_o` falls on the N-th consecutive clock edge at which `unit_busy_i` is low, where N is `idle_limit_i` (a value of 0 acts as 1).
- R3: A clock edge in RUN with `unit_busy_i` high clears the idle count, so no gating happens until N further consecutive idle edges occur.
- R4: In GATE_WAIT, `gate_req_o` stays high and `repower_req_o` stays low until the edge at which `gate_ack_i` is high, even if `unit_busy_i` is high.
- R5: In GATED, an edge with `unit_busy_i` high moves to WAKE: `gate_req_o` falls and `repower_req_o` rises.
- R6: `unit_ready_o` stays low throughout WAKE. It returns high (and `repower_req_o` falls) only after the edge at which `wake_ack_i` is high. The idle count restarts from zero.
- R7: `past_breakeven_o` rises once the unit has spent B edges in GATED with the residency counting, where B is `breakeven_limit_i`. It is low outside GATED.
- R8: A wake decided while the residency is below B increments `waste_count_o` by one. A wake decided at or after B leaves it unchanged.
- R9: `waste_count_o` saturates at its all-ones value.
- R10: Activity seen at any edge in GATE_WAIT is remembered. On the propagation acknowledge the controller goes straight to WAKE, and this is counted as a wasted episode when B>0.
- R11: `gate_ack_i` outside GATE_WAIT and `wake_ack_i` outside WAKE have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| unit_busy_i | input | 1 | Unit activity / work pending |
| idle_limit_i | input | IDLE_W | Idle edges before the gate decision |
| breakeven_limit_i | input | BE_W | Gated residency edges needed for break-even |
| gate_ack_i | input | 1 | Gate signal propagation complete |
| wake_ack_i | input | 1 | Supply fully recharged |
| gate_req_o | output | 1 | Supply off request (GATE_WAIT, GATED) |
| repower_req_o | output | 1 | Repower request (WAKE) |
| unit_ready_o | output | 1 | Unit may be used (RUN only) |
| past_breakeven_o | output | 1 | Current episode has passed break-even |
| waste_count_o | output | WASTE_W | Saturating count of premature wakes |

## Verification
Every output is a decode of registered state. Each result therefore appears one clock edge after the input edge that causes it:
- gate_req_o rises on the N-th idle edge.
- repower_req_o rises on the edge that samples activity in GATED, or on the acknowledge edge in GATE_WAIT.
- unit_ready_o returns on the edge that samples the wake acknowledge.
- past_breakeven_o rises on the B-th residency edge.
- waste_count_o steps on the same edge as the wake decision.

The bench changes inputs just after a falling edge and checks just after the next falling edge. Each check therefore observes exactly one rising edge's effect. Boundary checks sit at N-1 versus N idle edges and at B-1 versus B residency edges.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_GATE_WAIT = 2'd1,
        ST_GATED     = 2'd2,
        ST_WAKE      = 2'd3
    } pgc_state_t;
endpackage

// File: rtl/pgc_sat_counter.sv
module pgc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            count_o <= '0;
        else if (clr_i)
            count_o <= '0;
        else if (inc_i && (count_o != MAXV))
            count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/pgc_idle_timer.sv
module pgc_idle_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] limit_i,
    output logic         expire_o
);
    logic [W-1:0] cnt;

    pgc_sat_counter #(.W(W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_i),
        .inc_i   (inc_i),
        .count_o (cnt)
    );

    // The current idle edge would be the limit-th one.
    assign expire_o = ({1'b0, cnt} + {{W{1'b0}}, 1'b1}) >= {1'b0, limit_i};
endmodule

// File: rtl/pgc_residency.sv
module pgc_residency #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] limit_i,
    output logic         met_o
);
    logic [W-1:0] cnt;

    pgc_sat_counter #(.W(W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_i),
        .inc_i   (inc_i),
        .count_o (cnt)
    );

    assign met_o = (cnt >= limit_i);
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl #(
    parameter int IDLE_W  = 16,
    parameter int BE_W    = 16,
    parameter int WASTE_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               unit_busy_i,
    input  logic [IDLE_W-1:0]  idle_limit_i,
    input  logic [BE_W-1:0]    breakeven_limit_i,
    input  logic               gate_ack_i,
    input  logic               wake_ack_i,
    output logic               gate_req_o,
    output logic               repower_req_o,
    output logic               unit_ready_o,
    output logic               past_breakeven_o,
    output logic [WASTE_W-1:0] waste_count_o
);
    import pgc_pkg::*;

    pgc_state_t state_q, state_d;
    logic       wake_pend_q;
    logic       idle_expire;
    logic       be_met;
    logic       waste_inc;
    logic       in_run, in_gwait, in_gated;

    assign in_run   = (state_q == ST_RUN);
    assign in_gwait = (state_q == ST_GATE_WAIT);
    assign in_gated = (state_q == ST_GATED);

    pgc_idle_timer #(.W(IDLE_W)) u_idle (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (!in_run || unit_busy_i),
        .inc_i    (in_run && !unit_busy_i),
        .limit_i  (idle_limit_i),
        .expire_o (idle_expire)
    );

    pgc_residency #(.W(BE_W)) u_res (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (!in_gated),
        .inc_i   (in_gated),
        .limit_i (breakeven_limit_i),
        .met_o   (be_met)
    );

    pgc_sat_counter #(.W(WASTE_W)) u_waste (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (1'b0),
        .inc_i   (waste_inc),
        .count_o (waste_count_o)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:
                if (!unit_busy_i && idle_expire) state_d = ST_GATE_WAIT;   // idle_expire
            ST_GATE_WAIT:
                if (gate_ack_i)
                    state_d = (unit_busy_i || wake_pend_q) ? ST_WAKE       // early_wake
                                                           : ST_GATED;     // gate_done
            ST_GATED:
                if (unit_busy_i) state_d = ST_WAKE;                        // demand
            ST_WAKE:
                if (wake_ack_i) state_d = ST_RUN;                          // wake_done
            default: state_d = ST_RUN;
        endcase
    end

    // State register and pending-activity flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= ST_RUN;
            wake_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!in_gwait || gate_ack_i)
                wake_pend_q <= 1'b0;
            else if (unit_busy_i)
                wake_pend_q <= 1'b1;
        end
    end

    // Outputs and episode accounting
    always_comb begin
        gate_req_o       = 1'b0;
        repower_req_o    = 1'b0;
        unit_ready_o     = 1'b0;
        past_breakeven_o = 1'b0;
        unique case (state_q)
            ST_RUN:       unit_ready_o = 1'b1;
            ST_GATE_WAIT: gate_req_o   = 1'b1;
            ST_GATED: begin
                gate_req_o       = 1'b1;
                past_breakeven_o = be_met;
            end
            ST_WAKE:      repower_req_o = 1'b1;
            default:      unit_ready_o = 1'b0;
        endcase
        waste_inc = (state_d == ST_WAKE) && (state_q != ST_WAKE) && !be_met;
    end
endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk #(
    parameter int WASTE_W = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               unit_busy_i,
    input logic               gate_ack_i,
    input logic               wake_ack_i,
    input logic               gate_req_o,
    input logic               repower_req_o,
    input logic               unit_ready_o,
    input logic               past_breakeven_o,
    input logic [WASTE_W-1:0] waste_count_o
);
    // R2
    gate_rise_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_req_o) |-> ($past(!unit_busy_i) && !unit_ready_o));

    // R4
    gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_req_o && !past_breakeven_o && !gate_ack_i && !unit_busy_i) |=> gate_req_o);

    // R5
    gate_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(gate_req_o) |-> repower_req_o);

    // R6
    wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (repower_req_o && !wake_ack_i) |=> (repower_req_o && !unit_ready_o));

    // R6
    not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_req_o || repower_req_o) |-> !unit_ready_o);

    // R7
    breakeven_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_breakeven_o |-> gate_req_o);

    // R8
    waste_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(waste_count_o) |-> (waste_count_o == WASTE_W'($past(waste_count_o) + 1'b1)));

    // R9
    waste_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(&waste_count_o) |-> (&waste_count_o));
endmodule

bind pgate_ctrl pgate_ctrl_chk #(.WASTE_W(WASTE_W)) u_pgate_ctrl_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .unit_busy_i      (unit_busy_i),
    .gate_ack_i       (gate_ack_i),
    .wake_ack_i       (wake_ack_i),
    .gate_req_o       (gate_req_o),
    .repower_req_o    (repower_req_o),
    .unit_ready_o     (unit_ready_o),
    .past_breakeven_o (past_breakeven_o),
    .waste_count_o    (waste_count_o)
);

// File: tb/test_pgate_ctrl.sv
`timescale 1ns/100ps
module test_pgate_ctrl;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          busy = 1'b1;
    logic [15:0]   idle_lim = 16'd5;
    logic [15:0]   be_lim = 16'd4;
    logic          g_ack = 1'b0;
    logic          w_ack = 1'b0;
    logic          gate_req, rep_req, ready, pbe;
    logic [WW-1:0] waste;

    int tests = 0;
    int fails = 0;
    int exp_waste = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pgate_ctrl #(.IDLE_W(16), .BE_W(16), .WASTE_W(WW)) i_pgate_ctrl (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .unit_busy_i      (busy),
        .idle_limit_i     (idle_lim),
        .breakeven_limit_i(be_lim),
        .gate_ack_i       (g_ack),
        .wake_ack_i       (w_ack),
        .gate_req_o       (gate_req),
        .repower_req_o    (rep_req),
        .unit_ready_o     (ready),
        .past_breakeven_o (pbe),
        .waste_count_o    (waste)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bump_waste();
        if (exp_waste < (1 << WW) - 1) exp_waste++;
    endtask

    // Drive idle for L edges from RUN; checks boundary N-1 / N (R2)
    task automatic go_gate(input int lim);
        idle_lim = 16'(lim);
        busy = 1'b0;
        repeat (lim - 1) tick();
        chk("R2 gate low before limit", 32'(gate_req), 0);
        chk("R2 ready before limit", 32'(ready), 1);
        tick();
        chk("R2 gate at limit", 32'(gate_req), 1);
        chk("R2 ready falls", 32'(ready), 0);
    endtask

    task automatic ack_gate();
        g_ack = 1'b1; tick(); g_ack = 1'b0;
    endtask

    task automatic finish_wake();
        w_ack = 1'b1; tick(); w_ack = 1'b0;
        chk("R6 ready after wake ack", 32'(ready), 1);
        chk("R6 repower drops", 32'(rep_req), 0);
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(ready), 1);
        chk("R1 gate", 32'(gate_req), 0);
        chk("R1 repower", 32'(rep_req), 0);
        chk("R1 breakeven", 32'(pbe), 0);
        chk("R1 waste", 32'(waste), 0);
    endtask

    task automatic t_activity_reset();
        idle_lim = 16'd5;
        busy = 1'b0;
        repeat (4) tick();
        busy = 1'b1; tick();
        busy = 1'b0;
        repeat (4) tick();
        chk("R3 no gate after interrupted idle", 32'(gate_req), 0);
        tick();
        chk("R3 gate after full idle run", 32'(gate_req), 1);
        ack_gate();
        busy = 1'b1; tick(); bump_waste();
        finish_wake();
    endtask

    task automatic t_prop_wait();
        go_gate(3);
        busy = 1'b0;
        w_ack = 1'b1; tick(); w_ack = 1'b0;
        chk("R11 wake ack ignored in gate wait", 32'(gate_req), 1);
        tick(); tick();
        chk("R4 gate held", 32'(gate_req), 1);
        chk("R4 no repower", 32'(rep_req), 0);
        chk("R4 not ready", 32'(ready), 0);
        ack_gate();
        chk("R4 gated after ack", 32'(gate_req), 1);
        busy = 1'b1; tick(); bump_waste();
        chk("R5 repower on demand", 32'(rep_req), 1);
        chk("R5 gate drops", 32'(gate_req), 0);
        finish_wake();
    endtask

    task automatic t_profitable();
        be_lim = 16'd4;
        go_gate(2);
        ack_gate();
        repeat (3) tick();
        chk("R7 breakeven not yet", 32'(pbe), 0);
        tick();
        chk("R7 breakeven reached", 32'(pbe), 1);
        busy = 1'b1; tick();
        chk("R8 profitable wake no waste", 32'(waste), 32'(exp_waste));
        chk("R7 breakeven low outside gated", 32'(pbe), 0);
        g_ack = 1'b1; tick(); g_ack = 1'b0;
        chk("R11 gate ack ignored in wake", 32'(gate_req), 0);
        tick();
        chk("R6 ready low while waiting", 32'(ready), 0);
        chk("R6 repower held", 32'(rep_req), 1);
        finish_wake();
    endtask

    task automatic t_premature();
        be_lim = 16'd4;
        go_gate(2);
        ack_gate();
        repeat (3) tick();
        busy = 1'b1; tick(); bump_waste();
        chk("R8 premature wake counted", 32'(waste), 32'(exp_waste));
        chk("R5 repower", 32'(rep_req), 1);
        finish_wake();
    endtask

    task automatic t_early_activity();
        be_lim = 16'd4;
        go_gate(2);
        busy = 1'b1; tick();
        busy = 1'b0; tick();
        chk("R4 gate held despite activity", 32'(gate_req), 1);
        chk("R4 no repower before ack", 32'(rep_req), 0);
        ack_gate(); bump_waste();
        chk("R10 straight to repower", 32'(rep_req), 1);
        chk("R10 counted as waste", 32'(waste), 32'(exp_waste));
        finish_wake();
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 16; i++) begin
            go_gate(1);
            ack_gate();
            busy = 1'b1; tick(); bump_waste();
            finish_wake();
        end
        chk("R9 waste saturated", 32'(waste), 32'((1 << WW) - 1));
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_activity_reset();
        t_prop_wait();
        t_profitable();
        t_premature();
        t_early_activity();
        t_saturate();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule